// File: doc/BRIEF.md
# External Bus Yield Arbiter

This block lets an outside bus master borrow a processor's external memory bus. The outside master pulls an active-low request line, which may change at any time relative to the processor clock. The block passes it through a synchronizer. It then hands the bus over on the first cycle in which the processor is not in the middle of an external access. The handover changes three things on the same clock edge: the active-low grant goes low, the tristate enable for the address bus, data bus and memory strobes goes high, and the core is told to halt.

The handover happens at access boundaries, not instruction boundaries. An instruction that makes two external accesses can lose the bus in the one-cycle gap between them. An optional run-on mode keeps the core executing while the bus is away, and halts it only when it needs an external memory access. A separate active-low hung output shows that the processor wants the bus, for a memory or a DMA access, but is being held off. When the outside master releases its request, the grant, the hung flag, the tristate enable and the halt all clear on one edge, and the waiting access goes ahead. Arbitration does not depend on whether the processor core is in reset or booting.

Top module: `bus_yield_arbiter`

## Requirements
- R1: With no external access in progress, the grant output goes low on the third rising clock edge after the request input is seen low. That is the default two-stage synchronizer plus one register.
- R2: A grant happens as one event: ext_gnt_n goes low and bus_hiz goes high on the same edge. With run-on mode off, core_halt is high for as long as the bus is granted.
- R3: While acc_active is high, no grant is given. The grant comes on the first edge at which acc_active is sampled low and the synchronized request is present.
- R4: A single cycle with acc_active low, between two accesses of one instruction, is enough to grant the bus.
- R5: With run_on_en high, core_halt is high only while the bus is granted and mem_need is high. dma_need never raises core_halt.
- R6: Once the synchronized request is released, ext_gnt_n goes high, bus_hiz goes low and gnt_hung_n goes high on the same edge. From that edge core_halt is low.
- R7: core_in_reset has no effect on any output. The request is granted and released the same way whether or not the core is in reset.
- R8: gnt_hung_n is low exactly when the bus is granted and mem_need or dma_need was high at the edge that registered it. It is updated on every edge.
- R9: While rst_n is low, and until the internal reset release, ext_gnt_n and gnt_hung_n are high and bus_hiz and core_halt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset for this block, released synchronously inside |
| ext_req_n | input | 1 | Active-low bus request from the outside master, asynchronous |
| acc_active | input | 1 | An external memory access is in progress this cycle |
| mem_need | input | 1 | The core needs an external memory access |
| dma_need | input | 1 | The byte DMA engine needs an external access |
| run_on_en | input | 1 | 1 = core keeps running while the bus is granted |
| core_in_reset | input | 1 | The processor core is in reset or booting |
| ext_gnt_n | output | 1 | Active-low bus grant, registered |
| bus_hiz | output | 1 | 1 = tristate the address, data and strobe drivers, registered |
| core_halt | output | 1 | 1 = stall the core |
| gnt_hung_n | output | 1 | Active-low: the processor needs the bus but is held off, registered |

## Verification
The assertions assume that the processor never drives acc_active high while the grant is low, because a granted core cannot start an external access. The bench keeps to this by forcing acc_active low whenever its own model says the bus is granted. All other inputs, including the request line, mode and core reset, are changed freely on falling edges. The request toggles slowly enough that grants are held for many cycles, and it also sometimes toggles quickly enough to hit the synchronizer window.

// File: rtl/bya_pkg.sv
package bya_pkg;

  typedef enum logic {
    BUS_OWNED   = 1'b0,
    BUS_YIELDED = 1'b1
  } bus_state_e;

  typedef struct packed {
    logic gnt_n;
    logic hiz;
    logic hung_n;
  } bus_out_t;

  localparam bus_out_t BUS_OUT_IDLE = '{gnt_n: 1'b1, hiz: 1'b0, hung_n: 1'b1};

endpackage

// File: rtl/bya_reset_sync.sv
module bya_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bya_req_sync.sv
module bya_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async_n,
  output logic req_seen
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_comb stage_d[i] = ~req_async_n;
      end else begin : g_rest
        always_comb stage_d[i] = stage_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= 1'b0;
        else        stage_q[i] <= stage_d[i];
      end
    end
  endgenerate

  assign req_seen = stage_q[STAGES-1];
endmodule

// File: rtl/bya_grant_fsm.sv
module bya_grant_fsm
  import bya_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_seen,
  input  logic acc_active,
  input  logic mem_need,
  input  logic run_on_en,
  output logic grant_next,
  output logic granted,
  output logic core_halt
);
  bus_state_e state_q;
  bus_state_e state_d;
  logic       state_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BUS_OWNED:   if (req_seen && !acc_active) state_d = BUS_YIELDED;
      BUS_YIELDED: if (!req_seen)               state_d = BUS_OWNED;
      default:                                  state_d = BUS_OWNED;
    endcase
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= BUS_OWNED;
    else if (state_en) state_q <= state_d;
  end

  assign grant_next = (state_d == BUS_YIELDED);
  assign granted    = (state_q == BUS_YIELDED);
  assign core_halt  = granted && (!run_on_en || mem_need);
endmodule

// File: rtl/bya_out_stage.sv
module bya_out_stage
  import bya_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     grant_next,
  input  logic     need_any,
  output bus_out_t out_q
);
  bus_out_t out_d;
  logic     out_en;

  always_comb begin
    out_d.gnt_n  = ~grant_next;
    out_d.hiz    = grant_next;
    out_d.hung_n = ~(grant_next && need_any);
    out_en       = (out_d != out_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= BUS_OUT_IDLE;
    else if (out_en) out_q <= out_d;
  end
endmodule

// File: rtl/bus_yield_arbiter.sv
module bus_yield_arbiter
  import bya_pkg::*;
#(
  parameter int REQ_SYNC_STAGES = 2,
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_req_n,
  input  logic acc_active,
  input  logic mem_need,
  input  logic dma_need,
  input  logic run_on_en,
  input  logic core_in_reset,
  output logic ext_gnt_n,
  output logic bus_hiz,
  output logic core_halt,
  output logic gnt_hung_n
);
  logic     rst_n_int;
  logic     req_seen;
  logic     grant_next;
  logic     granted;
  logic     core_halt_int;
  logic     need_any;
  bus_out_t out_q;

  // core reset/boot state is deliberately not used: arbitration runs through it (R7)
  logic unused_core_rst;
  assign unused_core_rst = core_in_reset;

  bya_reset_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  bya_req_sync #(.STAGES(REQ_SYNC_STAGES)) u_req (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .req_async_n (ext_req_n),
    .req_seen    (req_seen)
  );

  bya_grant_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .req_seen   (req_seen),
    .acc_active (acc_active),
    .mem_need   (mem_need),
    .run_on_en  (run_on_en),
    .grant_next (grant_next),
    .granted    (granted),
    .core_halt  (core_halt_int)
  );

  assign need_any = mem_need || dma_need;

  bya_out_stage u_out (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .grant_next (grant_next),
    .need_any   (need_any),
    .out_q      (out_q)
  );

  assign ext_gnt_n  = out_q.gnt_n;
  assign bus_hiz    = out_q.hiz;
  assign gnt_hung_n = out_q.hung_n;
  assign core_halt  = core_halt_int;
endmodule

// File: rtl/bus_yield_arbiter_chk.sv
module bus_yield_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic acc_active,
  input logic mem_need,
  input logic run_on_en,
  input logic ext_gnt_n,
  input logic bus_hiz,
  input logic core_halt,
  input logic gnt_hung_n
);
  AST_GNT_HIZ_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    ext_gnt_n == !bus_hiz); // R2
  AST_HALT_WHILE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_gnt_n && !run_on_en) |-> core_halt); // R2
  AST_NO_GRANT_MID_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_gnt_n) |-> !$past(acc_active)); // R3
  AST_RUN_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_gnt_n && run_on_en && !mem_need) |-> !core_halt); // R5
  AST_OWNED_NOT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    ext_gnt_n |-> !core_halt); // R6
  AST_HUNG_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_hung_n |-> !ext_gnt_n); // R8
endmodule

bind bus_yield_arbiter bus_yield_arbiter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_active (acc_active),
  .mem_need   (mem_need),
  .run_on_en  (run_on_en),
  .ext_gnt_n  (ext_gnt_n),
  .bus_hiz    (bus_hiz),
  .core_halt  (core_halt),
  .gnt_hung_n (gnt_hung_n)
);

// File: tb/bus_yield_arbiter_test.sv
module bus_yield_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;

  logic clk;
  logic rst_n;
  logic ext_req_n, acc_active, mem_need, dma_need, run_on_en, core_in_reset;
  logic ext_gnt_n, bus_hiz, core_halt, gnt_hung_n;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 0;

  // reference model state
  logic [SYNC-1:0] m_sync;
  logic m_gnt, m_hung;

  bus_yield_arbiter uut (
    .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .acc_active(acc_active),
    .mem_need(mem_need), .dma_need(dma_need), .run_on_en(run_on_en),
    .core_in_reset(core_in_reset), .ext_gnt_n(ext_gnt_n), .bus_hiz(bus_hiz),
    .core_halt(core_halt), .gnt_hung_n(gnt_hung_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] expect_outs();
    logic halt;
    halt = m_gnt && (!run_on_en || mem_need);
    return {~m_gnt, m_gnt, halt, ~m_hung};
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: {gnt_n,hiz,halt,hung_n} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    logic req_s, g_next;
    @(posedge clk);
    req_s  = m_sync[SYNC-1];
    g_next = req_s && (m_gnt || !acc_active);
    m_hung = g_next && (mem_need || dma_need);
    m_gnt  = g_next;
    m_sync = {m_sync[SYNC-2:0], ~ext_req_n};
    @(negedge clk);
    chk(tag, {ext_gnt_n, bus_hiz, core_halt, gnt_hung_n}, expect_outs());
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      tests_failed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    int lat;
    void'($urandom(32'h1A2B3C4D));
    rst_n = 0; ext_req_n = 1; acc_active = 0; mem_need = 0; dma_need = 0;
    run_on_en = 0; core_in_reset = 0;
    m_sync = '0; m_gnt = 0; m_hung = 0;
    // R9: reset state, including a request held during reset
    ext_req_n = 0;
    repeat (4) @(negedge clk);
    chk("R9 reset", {ext_gnt_n, bus_hiz, core_halt, gnt_hung_n}, 4'b1001);
    ext_req_n = 1;
    @(negedge clk);
    rst_n = 1;
    repeat (6) step("R9 idle after reset");

    // R1: latency from request to grant
    ext_req_n = 0;
    lat = 0;
    for (int i = 0; i < 6; i++) begin
      step("R1 model");
      lat++;
      if (!ext_gnt_n) break;
    end
    tests_run++;
    if (lat != 3) begin
      tests_failed++;
      $display("FAIL R1 latency actual=%0d expected=3", lat);
    end
    // R2: halted while granted with run-on off
    chk("R2 grant set", {ext_gnt_n, bus_hiz, core_halt, gnt_hung_n}, 4'b0111);
    // R8: hung when need raised
    dma_need = 1;
    step("R8 hung dma");
    chk("R8 hung low", {3'b000, gnt_hung_n}, 4'b0000);
    dma_need = 0;
    // R5: run-on mode
    run_on_en = 1;
    step("R5 run-on idle");
    chk("R5 no halt", {3'b000, core_halt}, 4'b0000);
    dma_need = 1;
    step("R5 dma no halt");
    mem_need = 1;
    step("R5 mem halts");
    chk("R5 halt on mem", {3'b000, core_halt}, 4'b0001);
    // R6: release
    ext_req_n = 1;
    repeat (3) step("R6 release");
    chk("R6 released", {ext_gnt_n, bus_hiz, core_halt, gnt_hung_n}, 4'b1001);
    mem_need = 0; dma_need = 0; run_on_en = 0;
    step("R6 idle");

    // R3: access in progress defers grant
    acc_active = 1; ext_req_n = 0;
    repeat (6) step("R3 deferred");
    chk("R3 still owned", {3'b000, ext_gnt_n}, 4'b0001);
    acc_active = 0;
    step("R3 grant after access");
    chk("R3 granted", {3'b000, ext_gnt_n}, 4'b0000);
    ext_req_n = 1;
    repeat (4) step("R3 release");

    // R4: gap between two accesses
    acc_active = 1; ext_req_n = 0;
    repeat (4) step("R4 first access");
    acc_active = 0;
    step("R4 gap");
    chk("R4 granted in gap", {3'b000, ext_gnt_n}, 4'b0000);
    mem_need = 1;
    step("R4 second access waits");
    chk("R4 hung", {3'b000, gnt_hung_n}, 4'b0000);
    ext_req_n = 1;
    repeat (3) step("R4 release");
    chk("R4 hung cleared", {2'b00, ext_gnt_n, gnt_hung_n}, 4'b0011);
    mem_need = 0;

    // R7: core reset does not affect arbitration
    core_in_reset = 1; ext_req_n = 0;
    repeat (3) step("R7 in reset");
    chk("R7 grant in reset", {3'b000, ext_gnt_n}, 4'b0000);
    ext_req_n = 1;
    repeat (3) step("R7 release in reset");
    chk("R7 release in reset", {3'b000, ext_gnt_n}, 4'b0001);
    core_in_reset = 0;

    // random phase against the model (R1 R2 R3 R5 R6 R7 R8)
    for (int n = 0; n < 4000; n++) begin
      if (n % 250 == 0) run_on_en = $urandom_range(0, 1);
      if (($urandom % ((n % 500 < 60) ? 2 : 20)) == 0) ext_req_n = ~ext_req_n;
      acc_active    = m_gnt ? 1'b0 : ($urandom % 3 == 0);
      mem_need      = ($urandom % 4 == 0);
      dma_need      = ($urandom % 5 == 0);
      core_in_reset = ($urandom % 8 == 0);
      step("R8 random model");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule